// File: doc/BRIEF.md
# Flash Program Completion Poller

This block runs on the host side of a parallel flash device. After software has written a program command and its data byte, it starts the poller with the byte it expects to find. The poller then issues status reads, one after another, over a plain request/acknowledge read port. It watches three bits of every returned byte and ends with a one-cycle done pulse. A fail flag is raised in the same cycle if the operation failed.

The toggle bit is bit 6. It changes on every read while the device is busy. The poller keeps the toggle bit from the previous read and compares each new read against it. The operation counts as finished once the toggle bit holds still and bits 7 and 6 equal the expected byte. No verify read follows, because the device returns to array reads by itself.

Bit 5 is the device's own timeout flag. When a read shows it, the poller makes two more reads before it decides. An optional read-count limit acts as a host watchdog on top of this.

Top module: `flash_done_poller`

## Requirements
- R1: While idle, a high `start_i` latches bits 7 and 6 of `exp_data_i`. `rd_req_o` is high from the next cycle until the deciding read. Each cycle with `rd_req_o` and `rd_ack_i` both high is one read, and `rd_data_i` is sampled in that cycle. Reads carry no address. While idle, `rd_ack_i` and `rd_data_i` are ignored.
- R2: A read ends the operation with success when three things hold: it is not the first read of the operation, its bit 6 equals bit 6 of the previous read, and its bits 7:6 equal the latched bits 7:6. The first read can never complete.
- R3: A read that does not complete and has bit 5 = 1 starts a confirmation phase of exactly two further reads. Bit 5 on later reads does not restart it.
- R4: If the second confirmation read does not complete under R2, it ends the operation. The result is fail when its bit 6 differs from the previous read's bit 6, and success otherwise.
- R5: When `limit_i` is non-zero, read number `limit_i` ends the operation with fail unless R2 or R4 decide that read first. When `limit_i` = 0, there is no read limit.
- R6: `done_o` is high for exactly one cycle, in the cycle after the deciding read. `fail_o` is high in that same cycle only for a fail result. `rd_req_o` is low in that cycle, and the block is idle again.
- R7: During reset and right after it, `done_o`, `fail_o` and `rd_req_o` are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Begin polling (accepted while idle) |
| exp_data_i | input | 8 | Byte that was programmed |
| limit_i | input | CNT_W | Read limit, 0 = unlimited |
| rd_req_o | output | 1 | Status read request |
| rd_ack_i | input | 1 | Read completes this cycle |
| rd_data_i | input | 8 | Status byte returned with the acknowledge |
| done_o | output | 1 | One-cycle end-of-operation pulse |
| fail_o | output | 1 | Fail qualifier, valid with `done_o` |

## Verification
The bench builds the poller with `CNT_W` = 8. This keeps limits of two or three reads cheap to reach. It can then land the watchdog on the very read that also completes or that ends confirmation, so the priority between the rules can be checked. The sequences cover toggling that stops with a wrong bit 7, the timeout flag on the first read and on a later read, confirmation ending in either result, and a long unlimited run. Each one checks both the result and the exact number of reads used.

// File: rtl/flash_done_poller.sv
module flash_done_poller #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic [7:0]       exp_data_i,
  input  logic [CNT_W-1:0] limit_i,
  output logic             rd_req_o,
  input  logic             rd_ack_i,
  input  logic [7:0]       rd_data_i,
  output logic             done_o,
  output logic             fail_o
);

  logic             busy, have_prev, prev6, confirm, conf_seen;
  logic [1:0]       want;
  logic [CNT_W-1:0] cnt;

  wire rd       = busy & rd_ack_i;
  wire stable   = have_prev & (rd_data_i[6] == prev6);
  wire complete = stable & (rd_data_i[7:6] == want);
  wire conf_end = confirm & conf_seen;
  wire wd_hit   = (limit_i != '0) && ((cnt + 1'b1) == limit_i);
  wire finish   = complete | conf_end | wd_hit;
  wire is_fail  = !complete & (conf_end ? !stable : wd_hit);

  assign rd_req_o = busy;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy      <= 1'b0;
      have_prev <= 1'b0;
      prev6     <= 1'b0;
      confirm   <= 1'b0;
      conf_seen <= 1'b0;
      want      <= 2'b00;
      cnt       <= '0;
      done_o    <= 1'b0;
      fail_o    <= 1'b0;
    end else begin
      done_o <= 1'b0;
      fail_o <= 1'b0;
      if (!busy && start_i) begin
        busy      <= 1'b1;
        want      <= exp_data_i[7:6];
        have_prev <= 1'b0;
        confirm   <= 1'b0;
        conf_seen <= 1'b0;
        cnt       <= '0;
      end else if (rd) begin
        prev6     <= rd_data_i[6];
        have_prev <= 1'b1;
        cnt       <= cnt + 1'b1;
        if (confirm)
          conf_seen <= 1'b1;
        else if (rd_data_i[5] && !complete)
          confirm <= 1'b1;
        if (finish) begin
          busy   <= 1'b0;
          done_o <= 1'b1;
          fail_o <= is_fail;
        end
      end
    end
  end

endmodule

module flash_done_poller_chk (
  input logic clk,
  input logic rst_n,
  input logic start_i,
  input logic rd_req_o,
  input logic rd_ack_i,
  input logic done_o,
  input logic fail_o
);

  p_done_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  p_fail_qual_r6: assert property (@(posedge clk) disable iff (!rst_n)
    fail_o |-> done_o);

  p_idle_at_done_r6: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> !rd_req_o);

  p_start_req_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (!rd_req_o && start_i) |=> rd_req_o);

  p_done_after_read_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done_o) |-> $past(rd_req_o && rd_ack_i));

  p_req_holds_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req_o && !rd_ack_i) |=> rd_req_o);

endmodule

bind flash_done_poller flash_done_poller_chk i_chk (
  .clk(clk), .rst_n(rst_n), .start_i(start_i), .rd_req_o(rd_req_o),
  .rd_ack_i(rd_ack_i), .done_o(done_o), .fail_o(fail_o)
);

// File: tb/test_flash_done_poller.sv
module test_flash_done_poller;
  localparam int CW = 8;
  localparam int NV = 9;

  // {exp[67:60], limit[59:52], six reads[51:4] first in MSBs, fail[3], nreads[2:0]}
  localparam logic [67:0] VEC [NV] = '{
    {8'hA5, 8'd0, 48'h40_00_A5_A5_00_00, 1'b0, 3'd3}, // R2 basic
    {8'h3C, 8'd0, 48'h3C_3C_00_00_00_00, 1'b0, 3'd2}, // R2 first read cannot complete
    {8'h80, 8'd0, 48'h00_00_80_80_00_00, 1'b0, 3'd3}, // R2 stable but bit7 wrong
    {8'h80, 8'd0, 48'h40_20_60_20_00_00, 1'b1, 3'd4}, // R3 R4 still toggling -> fail
    {8'h80, 8'd0, 48'h40_20_00_00_00_00, 1'b0, 3'd4}, // R4 stopped toggling -> success
    {8'h80, 8'd3, 48'h40_00_40_00_00_00, 1'b1, 3'd3}, // R5 watchdog
    {8'hC0, 8'd0, 48'h00_40_00_40_C0_C0, 1'b0, 3'd5}, // R5 limit 0 unlimited
    {8'h3C, 8'd2, 48'h3C_3C_00_00_00_00, 1'b0, 3'd2}, // R5 completion wins on limit read
    {8'h80, 8'd0, 48'h20_60_20_00_00_00, 1'b1, 3'd3}  // R3 bit5 on first read
  };

  logic clk = 0, rst_n = 0, start_i = 0, rd_ack_i = 0;
  logic [7:0] exp_data_i = 0, rd_data_i = 0;
  logic [CW-1:0] limit_i = 0;
  logic rd_req_o, done_o, fail_o;
  int checks = 0, fails = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  flash_done_poller #(.CNT_W(CW)) i_flash_done_poller (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .exp_data_i(exp_data_i),
    .limit_i(limit_i), .rd_req_o(rd_req_o), .rd_ack_i(rd_ack_i),
    .rd_data_i(rd_data_i), .done_o(done_o), .fail_o(fail_o));

  task automatic chk(input bit ok, input string req, input int got, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s got %0d expected %0d", req, got, exp);
    end
  endtask

  task automatic run_op(input logic [7:0] e, input logic [7:0] l, input logic [47:0] rs,
                        output logic f, output int n, output logic clean);
    n = 0; f = 0; clean = 0;
    @(negedge clk); start_i = 1; exp_data_i = e; limit_i = l;
    @(negedge clk); start_i = 0;
    for (int c = 0; c < 40; c++) begin
      rd_ack_i = 0;
      if (done_o) begin
        f = fail_o;
        @(negedge clk);
        clean = !done_o && !fail_o && !rd_req_o;
        return;
      end
      if (rd_req_o) begin
        rd_ack_i = 1;
        rd_data_i = (n < 6) ? rs[47-8*n -: 8] : 8'h40;
        n++;
      end
      @(negedge clk);
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      checks++; fails++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    logic f, clean;
    int n;
    repeat (3) @(negedge clk);
    chk(!done_o && !fail_o && !rd_req_o, "R7 reset outputs", {done_o, fail_o, rd_req_o}, 0);
    rst_n = 1;
    @(negedge clk);
    chk(!done_o && !fail_o && !rd_req_o, "R7 after reset", {done_o, fail_o, rd_req_o}, 0);

    for (int i = 0; i < NV; i++) begin
      run_op(VEC[i][67:60], VEC[i][59:52], VEC[i][51:4], f, n, clean);
      chk(f == VEC[i][3], $sformatf("R2 R4 R5 vector %0d result", i), f, VEC[i][3]);
      chk(n == VEC[i][2:0], $sformatf("R1 R3 vector %0d reads", i), n, VEC[i][2:0]);
      chk(clean, $sformatf("R6 vector %0d single pulse and idle", i), clean, 1);
    end

    // R1: acknowledges while idle are ignored
    rd_data_i = 8'h80; rd_ack_i = 1;
    for (int c = 0; c < 3; c++) begin
      @(negedge clk);
      chk(!done_o && !rd_req_o, "R1 idle ack ignored", {done_o, rd_req_o}, 0);
    end
    rd_ack_i = 0;

    // R3: later bit5 does not restart confirmation; second confirm read toggled -> fail
    run_op(8'h80, 8'd0, 48'h20_60_30_00_00_00, f, n, clean);
    chk(f == 1 && n == 3, "R3 no restart", n, 3);

    // R5: confirmation end stable beats watchdog on the same read
    run_op(8'h80, 8'd4, 48'h40_20_00_00_00_00, f, n, clean);
    chk(f == 0 && n == 4, "R5 confirm beats watchdog", f, 0);

    // R1: rd_req held while ack withheld
    @(negedge clk); start_i = 1; exp_data_i = 8'h3C; limit_i = 0;
    @(negedge clk); start_i = 0;
    repeat (3) @(negedge clk);
    chk(rd_req_o && !done_o, "R1 req held without ack", rd_req_o, 1);
    run_op(8'h00, 8'd0, 48'h3C_3C_00_00_00_00, f, n, clean);
    chk(f == 0 && n == 2, "R1 R2 resumed op", n, 2);

    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule